// File: doc/BRIEF.md
# Ethernet PHY Receive Status and Error Signalling

This block forms the receive-side status outputs that a 10/100 Ethernet PHY presents to its MAC over the MII. Two of these outputs are combinational and unclocked. The collision indicator and the carrier-sense indicator come straight from the receive-activity and transmit-enable levels. Their meaning depends on the duplex setting, on whether serial 10 Mbit/s operation is selected, and on a carrier-sense mode select. In serial 10 Mbit/s operation the collision pin is reused to show that the jabber timer has expired.

The receive data nibble, its valid flag and the receive error flag are registered on the falling edge of the receive clock. At 100 Mbit/s the decoder raises single-cycle strobes for four kinds of error. When a strobe arrives, the block raises the error flag for one nibble period and replaces the nibble with a numbered code. Two of the error kinds can each be switched off on its own. In serial 10 Mbit/s operation only the lowest data bit is driven. The three upper bits have their output enables held low, and the valid flag stays inactive.

Top module: `mii_rx_status`

## Requirements
- R1: In half duplex, when serial 10 Mbit/s operation is not selected, `col` equals `tx_en AND rx_active` with no clock delay.
- R2: When `full_duplex` is high, `col` is low, whatever the other inputs are.
- R3: In half duplex with serial 10 Mbit/s operation selected (`serial_sel` high, `speed_100` low), `col` follows `jabber_expired`.
- R4: With `crs_rx_only` low, `crs` is `tx_en OR rx_active`, so it stays high through a collision.
- R5: With `crs_rx_only` high, `crs` follows `rx_active` alone.
- R6: At 100 Mbit/s an error strobe sets `rx_er` at the next falling edge and loads a code onto `rxd`: 5h for code error, 4h for premature end, 3h for link error, 2h for packet error. If several strobes arrive together, the priority is code, then premature end, then link, then packet.
- R7: A packet-error strobe has no effect while `pkt_err_en` is low, and a link-error strobe has no effect while `link_err_en` is low. In each case `rx_er` stays low and the decoded nibble passes through.
- R8: At 10 Mbit/s (`speed_100` low) `rx_er` is held low and error strobes are ignored.
- R9: In serial 10 Mbit/s operation `rxd_oe` is 4'b0001, `rxd[3:1]` are driven 0, `rxd[0]` carries the decoded bit 0, and `rx_dv` stays low. Otherwise `rxd_oe` is 4'b1111.
- R10: `rxd` and `rx_dv` take the decoded nibble and its valid flag at each falling clock edge. An error code lasts exactly one nibble period, and the next period returns to decoded data.
- R11: While reset is asserted, `rx_er`, `rx_dv` and `rxd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; outputs update on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100 | input | 1 | 1 = 100 Mbit/s, 0 = 10 Mbit/s |
| serial_sel | input | 1 | Serial data mode select (effective at 10 Mbit/s) |
| full_duplex | input | 1 | Full duplex selected |
| crs_rx_only | input | 1 | Carrier sense follows receive only |
| rx_active | input | 1 | Receive activity on the medium |
| tx_en | input | 1 | Transmit enable from the MAC |
| jabber_expired | input | 1 | Jabber timer expired flag |
| pkt_err_en | input | 1 | Enable for packet-error code |
| link_err_en | input | 1 | Enable for link-error code |
| err_packet | input | 1 | Packet-error strobe |
| err_link | input | 1 | Link-error strobe |
| err_premature | input | 1 | Premature-end strobe |
| err_code | input | 1 | Code-error strobe |
| dec_nibble | input | 4 | Decoded receive nibble |
| dec_valid | input | 1 | Decoded nibble valid |
| col | output | 1 | Collision / jabber indication |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rxd | output | 4 | Receive data nibble |
| rxd_oe | output | 4 | Per-bit output enables for rxd |

## Verification
Directed patterns go through every combination of duplex, serial mode and carrier-sense select while transmit and receive activity vary. This tells apart the plain AND, the forced-low and the jabber meanings of the collision output, and the two carrier-sense meanings. Error strobes are applied alone, in pairs and all together, with each enable on and off and at both speeds. This exposes any wrong code value, a wrong priority order, a missing enable gate or a leak at 10 Mbit/s. A following cycle of clean data then shows that the code lasts only one nibble period. A long stretch of random inputs is then compared cycle by cycle against a behavioural model, to catch interactions between modes that the directed patterns miss.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [NIB_W-1:0] {
    ERRC_NONE      = 4'h0,
    ERRC_PACKET    = 4'h2,
    ERRC_LINK      = 4'h3,
    ERRC_PREMATURE = 4'h4,
    ERRC_CODING    = 4'h5
  } errc_e;
endpackage

// File: rtl/mii_rx_rst_sync.sv
module mii_rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mii_rx_line_status.sv
module mii_rx_line_status (
  input  logic full_duplex,
  input  logic serial10,
  input  logic crs_rx_only,
  input  logic rx_active,
  input  logic tx_en,
  input  logic jabber_expired,
  output logic col,
  output logic crs
);
  always_comb begin
    if (full_duplex)   col = 1'b0;
    else if (serial10) col = jabber_expired;
    else               col = tx_en & rx_active;
  end

  always_comb begin
    if (crs_rx_only) crs = rx_active;
    else             crs = rx_active | tx_en;
  end
endmodule

// File: rtl/mii_rx_err_select.sv
module mii_rx_err_select
  import mii_rx_pkg::*;
(
  input  logic  speed_100,
  input  logic  pkt_err_en,
  input  logic  link_err_en,
  input  logic  err_packet,
  input  logic  err_link,
  input  logic  err_premature,
  input  logic  err_code,
  output logic  err_hit,
  output errc_e err_val
);
  always_comb begin
    err_val = ERRC_NONE;
    if (speed_100) begin
      if (err_code)                      err_val = ERRC_CODING;
      else if (err_premature)            err_val = ERRC_PREMATURE;
      else if (err_link && link_err_en)  err_val = ERRC_LINK;
      else if (err_packet && pkt_err_en) err_val = ERRC_PACKET;
    end
    err_hit = (err_val != ERRC_NONE);
  end
endmodule

// File: rtl/mii_rx_status.sv
module mii_rx_status
  import mii_rx_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             speed_100,
  input  logic             serial_sel,
  input  logic             full_duplex,
  input  logic             crs_rx_only,
  input  logic             rx_active,
  input  logic             tx_en,
  input  logic             jabber_expired,
  input  logic             pkt_err_en,
  input  logic             link_err_en,
  input  logic             err_packet,
  input  logic             err_link,
  input  logic             err_premature,
  input  logic             err_code,
  input  logic [NIB_W-1:0] dec_nibble,
  input  logic             dec_valid,
  output logic             col,
  output logic             crs,
  output logic             rx_dv,
  output logic             rx_er,
  output logic [NIB_W-1:0] rxd,
  output logic [NIB_W-1:0] rxd_oe
);
  logic             rst_int_n;
  logic             serial10;
  logic             err_hit;
  errc_e            err_val;
  logic             rx_er_d, rx_er_q;
  logic             rx_dv_d, rx_dv_q;
  logic [NIB_W-1:0] rxd_d, rxd_q;
  logic [NIB_W-1:0] data_mask;

  assign serial10 = serial_sel & ~speed_100;

  mii_rx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mii_rx_line_status u_line (
    .full_duplex    (full_duplex),
    .serial10       (serial10),
    .crs_rx_only    (crs_rx_only),
    .rx_active      (rx_active),
    .tx_en          (tx_en),
    .jabber_expired (jabber_expired),
    .col            (col),
    .crs            (crs)
  );

  mii_rx_err_select u_err (
    .speed_100     (speed_100),
    .pkt_err_en    (pkt_err_en),
    .link_err_en   (link_err_en),
    .err_packet    (err_packet),
    .err_link      (err_link),
    .err_premature (err_premature),
    .err_code      (err_code),
    .err_hit       (err_hit),
    .err_val       (err_val)
  );

  for (genvar b = 0; b < NIB_W; b++) begin : g_bit
    if (b == 0) begin : g_lsb
      assign data_mask[b] = 1'b1;
    end else begin : g_upper
      assign data_mask[b] = ~serial10;
    end
  end

  assign rxd_oe = data_mask;

  always_comb begin
    rx_er_d = err_hit;
    rx_dv_d = dec_valid & ~serial10;
    if (err_hit) rxd_d = err_val;
    else         rxd_d = dec_nibble & data_mask;
  end

  always_ff @(negedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rx_er_q <= 1'b0;
      rx_dv_q <= 1'b0;
      rxd_q   <= '0;
    end else begin
      rx_er_q <= rx_er_d;
      rx_dv_q <= rx_dv_d;
      rxd_q   <= rxd_d;
    end
  end

  assign rx_er = rx_er_q;
  assign rx_dv = rx_dv_q;
  assign rxd   = rxd_q;
endmodule

// File: rtl/mii_rx_status_chk.sv
module mii_rx_status_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       speed_100,
  input logic       serial_sel,
  input logic       full_duplex,
  input logic       crs_rx_only,
  input logic       rx_active,
  input logic       tx_en,
  input logic       jabber_expired,
  input logic       pkt_err_en,
  input logic       link_err_en,
  input logic       err_packet,
  input logic       err_link,
  input logic       err_premature,
  input logic       err_code,
  input logic       dec_valid,
  input logic       col,
  input logic       crs,
  input logic       rx_dv,
  input logic       rx_er,
  input logic [3:0] rxd,
  input logic [3:0] rxd_oe
);
  logic armed;
  logic ser10;
  assign ser10 = serial_sel & ~speed_100;

  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  p_col_and_r1: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (armed && !full_duplex && !ser10) |-> (col == (tx_en && rx_active)));
  p_col_fdx_r2: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (armed && full_duplex) |-> !col);
  p_col_jab_r3: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (armed && !full_duplex && ser10) |-> (col == jabber_expired));
  p_crs_any_r4: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (armed && !crs_rx_only) |-> (crs == (tx_en || rx_active)));
  p_crs_rx_r5: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (armed && crs_rx_only) |-> (crs == rx_active));
  p_code_r6: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (armed && $past(speed_100 && err_code)) |-> (rx_er && rxd == 4'h5));
  p_pkt_off_r7: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (armed && $past(err_packet && !pkt_err_en && !err_link && !err_premature && !err_code))
    |-> !rx_er);
  p_er10_r8: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (armed && !$past(speed_100)) |-> !rx_er);
  p_oe_r9: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (armed && ser10) |-> (rxd_oe == 4'b0001));
  p_dv_ser_r9: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (armed && $past(ser10)) |-> !rx_dv);
  p_dv_r10: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (armed && $past(dec_valid && !ser10)) |-> rx_dv);
endmodule

bind mii_rx_status mii_rx_status_chk u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_int_n),
  .speed_100      (speed_100),
  .serial_sel     (serial_sel),
  .full_duplex    (full_duplex),
  .crs_rx_only    (crs_rx_only),
  .rx_active      (rx_active),
  .tx_en          (tx_en),
  .jabber_expired (jabber_expired),
  .pkt_err_en     (pkt_err_en),
  .link_err_en    (link_err_en),
  .err_packet     (err_packet),
  .err_link       (err_link),
  .err_premature  (err_premature),
  .err_code       (err_code),
  .dec_valid      (dec_valid),
  .col            (col),
  .crs            (crs),
  .rx_dv          (rx_dv),
  .rx_er          (rx_er),
  .rxd            (rxd),
  .rxd_oe         (rxd_oe)
);

// File: tb/tb_mii_rx_status.sv
module tb_mii_rx_status;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic speed_100, serial_sel, full_duplex, crs_rx_only;
  logic rx_active, tx_en, jabber_expired;
  logic pkt_err_en, link_err_en;
  logic err_packet, err_link, err_premature, err_code;
  logic [3:0] dec_nibble;
  logic dec_valid;
  logic col, crs, rx_dv, rx_er;
  logic [3:0] rxd, rxd_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  mii_rx_status dut (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .serial_sel(serial_sel),
    .full_duplex(full_duplex), .crs_rx_only(crs_rx_only), .rx_active(rx_active),
    .tx_en(tx_en), .jabber_expired(jabber_expired), .pkt_err_en(pkt_err_en),
    .link_err_en(link_err_en), .err_packet(err_packet), .err_link(err_link),
    .err_premature(err_premature), .err_code(err_code), .dec_nibble(dec_nibble),
    .dec_valid(dec_valid), .col(col), .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er),
    .rxd(rxd), .rxd_oe(rxd_oe)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic clear_inputs();
    {speed_100, serial_sel, full_duplex, crs_rx_only} = '0;
    {rx_active, tx_en, jabber_expired, pkt_err_en, link_err_en} = '0;
    {err_packet, err_link, err_premature, err_code, dec_valid} = '0;
    dec_nibble = 4'h0;
  endtask

  // Behavioural reference: outputs expected after the falling edge that follows input setup.
  task automatic compare();
    bit ser10, any_err, off_strobe;
    logic [3:0] e_rxd, e_oe;
    logic e_col, e_crs, e_er, e_dv;
    string col_tag, crs_tag, er_tag, rxd_tag, dv_tag;
    ser10 = serial_sel && !speed_100;
    if (full_duplex) begin e_col = 0; col_tag = "R2"; end
    else if (ser10) begin e_col = jabber_expired; col_tag = "R3"; end
    else begin e_col = tx_en && rx_active; col_tag = "R1"; end
    if (crs_rx_only) begin e_crs = rx_active; crs_tag = "R5"; end
    else begin e_crs = rx_active || tx_en; crs_tag = "R4"; end
    e_er = 0; e_rxd = ser10 ? {3'b000, dec_nibble[0]} : dec_nibble;
    if (speed_100) begin
      if (err_code) begin e_er = 1; e_rxd = 4'h5; end
      else if (err_premature) begin e_er = 1; e_rxd = 4'h4; end
      else if (err_link && link_err_en) begin e_er = 1; e_rxd = 4'h3; end
      else if (err_packet && pkt_err_en) begin e_er = 1; e_rxd = 4'h2; end
    end
    any_err = err_code || err_premature || err_link || err_packet;
    off_strobe = (err_packet && !pkt_err_en) || (err_link && !link_err_en);
    er_tag = !speed_100 ? "R8" : (off_strobe && !e_er) ? "R7" : "R6";
    rxd_tag = e_er ? "R6" : ser10 ? "R9" : (any_err ? er_tag : "R10");
    e_dv = dec_valid && !ser10;
    dv_tag = ser10 ? "R9" : "R10";
    e_oe = ser10 ? 4'b0001 : 4'b1111;
    @(negedge clk);
    #2;
    chk(col_tag, "col", {3'b0, col}, {3'b0, e_col});
    chk(crs_tag, "crs", {3'b0, crs}, {3'b0, e_crs});
    chk(er_tag, "rx_er", {3'b0, rx_er}, {3'b0, e_er});
    chk(rxd_tag, "rxd", rxd, e_rxd);
    chk(dv_tag, "rx_dv", {3'b0, rx_dv}, {3'b0, e_dv});
    chk("R9", "rxd_oe", rxd_oe, e_oe);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    dec_nibble = 4'hA; dec_valid = 1'b1; speed_100 = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    // R11: reset state of the registered outputs
    chk("R11", "rx_er", {3'b0, rx_er}, 4'h0);
    chk("R11", "rx_dv", {3'b0, rx_dv}, 4'h0);
    chk("R11", "rxd", rxd, 4'h0);
    clear_inputs();
    rst_n = 1'b1;
    repeat (4) begin step(); compare(); end

    // R1 / R4 / R5: half duplex, all activity combinations, both CRS modes
    for (int m = 0; m < 16; m++) begin
      step(); clear_inputs(); speed_100 = 1;
      tx_en = m[0]; rx_active = m[1]; crs_rx_only = m[2]; jabber_expired = m[3];
      compare();
    end
    // R2: full duplex forces col low; R3: serial 10M col shows jabber
    for (int m = 0; m < 32; m++) begin
      step(); clear_inputs();
      full_duplex = m[4]; serial_sel = m[3]; speed_100 = m[2];
      tx_en = 1; rx_active = 1; jabber_expired = m[0]; crs_rx_only = m[1];
      compare();
    end
    // R6: each code alone, then priority combinations, then R10 data resumes
    for (int m = 1; m < 16; m++) begin
      step(); clear_inputs(); speed_100 = 1; pkt_err_en = 1; link_err_en = 1;
      err_packet = m[0]; err_link = m[1]; err_premature = m[2]; err_code = m[3];
      dec_nibble = 4'h9; dec_valid = 1;
      compare();
      step(); clear_inputs(); speed_100 = 1; dec_nibble = 4'hC; dec_valid = 1;
      compare();
    end
    // R7: disabled packet/link strobes are ignored; enabled link beats packet
    for (int m = 0; m < 16; m++) begin
      step(); clear_inputs(); speed_100 = 1; dec_valid = 1; dec_nibble = 4'h7;
      pkt_err_en = m[0]; link_err_en = m[1]; err_packet = m[2]; err_link = m[3];
      compare();
    end
    // R8: strobes at 10 Mbit/s are ignored
    for (int m = 0; m < 4; m++) begin
      step(); clear_inputs(); speed_100 = 0; serial_sel = m[0];
      err_code = 1; err_premature = 1; err_link = 1; err_packet = 1;
      pkt_err_en = 1; link_err_en = 1; dec_valid = 1; dec_nibble = 4'hF - 4'(m);
      compare();
    end
    // R9 / R10: serial mode data bit and valid flag, nibble mode data pass
    for (int m = 0; m < 16; m++) begin
      step(); clear_inputs(); serial_sel = m[0]; speed_100 = m[1];
      dec_valid = 1; dec_nibble = 4'(m) ^ 4'hB;
      compare();
    end
    // Random mix against the reference model
    for (int i = 0; i < 2000; i++) begin
      logic [19:0] r;
      step();
      r = 20'($urandom);
      {speed_100, serial_sel, full_duplex, crs_rx_only} = r[3:0];
      {rx_active, tx_en, jabber_expired, pkt_err_en, link_err_en} = r[8:4];
      err_packet = r[9] & r[10]; err_link = r[11] & r[12];
      err_premature = r[13] & r[14]; err_code = r[15] & r[10];
      dec_valid = r[16] | r[9]; dec_nibble = r[19:16] ^ r[3:0];
      compare();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule